// File: doc/BRIEF.md
# Dual-View Modem Control Register

This block holds the modem control register of a UART and presents it in one of two bit layouts, chosen by a mode input: a legacy view and an extended view. In both views bits 0 and 1 drive the active-low data-terminal-ready and request-to-send pins. In the legacy view the upper bits give a spare loopback bit, an interrupt-enable gate and the loopback select. In the extended view the upper bits give DMA enable, transmit deferral, an infrared pulse control and a 3-bit mode select. These are exported to the rest of the UART.

The loopback flag has a single storage bit. It can be written through this register in the legacy view, or through a second one-bit write port that stands for the same bit of an extended control register. When loopback is active, the block feeds register bits into the internal modem-status lines in place of the external status inputs. The mapping differs between the views. The external pins are also held inactive. The status lines leave on `mstat_o` as {dcd, ri, cts, dsr}, with bit 0 = dsr.

Top module: `mcr_dual_view`

## Requirements
- R1: After an asynchronous reset all stored bits are 0: reads return 8'h00, dtr_no_o and rts_no_o are 1, loop_o is 0, and every extended export is 0.
- R2: Outside loopback, dtr_no_o is the inverse of stored bit 0 and rts_no_o is the inverse of stored bit 1. While loopback is active both pins are 1.
- R3: In the legacy view with loopback active: dsr follows bit 0, cts follows bit 1, ri follows legacy bit 2, and dcd follows legacy bit 3.
- R4: In the extended view with loopback active: both dsr and ri follow bit 0, and both cts and dcd follow bit 1.
- R5: Outside loopback, mstat_o equals ext_stat_i ({dcd, ri, cts, dsr}). While loopback is active, ext_stat_i has no effect on mstat_o.
- R6: irq_en_o equals legacy bit 3 in the legacy view outside loopback. It is 1 in loopback. It is 1 in the extended view.
- R7: A register write in the legacy view sets the loopback flag from bit 4. A register write in the extended view leaves the flag unchanged. An alias write sets the flag from alias_loop_i and takes priority over a same-cycle register write. loop_o shows the flag.
- R8: Bits 0 and 1 are common to both views. Bits 2 to 7 are stored separately per view, so a write in one view and any change of mode leave the other view's bits unchanged.
- R9: Reads are combinational. In the legacy view a read returns {3'b000, loop, bit3, bit2, bit1, bit0}, with reserved bits 7 to 5 reading 0. In the extended view a read returns {msel[2:0], ir_pulse, tx_defer, dma_en, bit1, bit0}.
- R10: In the extended view the outputs are dma_en_o = bit 2, tx_defer_o = bit 3, ir_pulse_o = bit 4 and mode_sel_o = bits 7 to 5. In the legacy view all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 selects the extended view |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| alias_we_i | input | 1 | Write strobe for the loopback alias |
| alias_loop_i | input | 1 | Loopback value written via the alias |
| ext_stat_i | input | 4 | External modem status {dcd, ri, cts, dsr}, active high |
| rd_data_o | output | 8 | Register read data in the current view |
| dtr_no_o | output | 1 | Data terminal ready pin, active low |
| rts_no_o | output | 1 | Request to send pin, active low |
| irq_en_o | output | 1 | Interrupt output gate |
| mstat_o | output | 4 | Internal modem status {dcd, ri, cts, dsr} |
| loop_o | output | 1 | Shared loopback flag |
| dma_en_o | output | 1 | DMA enable export |
| tx_defer_o | output | 1 | Transmit deferral export |
| ir_pulse_o | output | 1 | Infrared pulse export |
| mode_sel_o | output | 3 | Mode select export |

## Verification
A write changes storage at the clock edge that samples it. Every result (read data, pins, status lines, interrupt gate and exports) is a combinational function of that storage, the mode and the status inputs. So each result is due in the same cycle as the edge, with no further register stages. The bench drives each stimulus at a falling edge, lets one rising edge take it, and samples at the next falling edge, before new stimulus is applied. Mode and status inputs take effect without an edge. The bench still samples them only at falling edges.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int DATA_W = 8;
  localparam int MSEL_W = 3;
  localparam int STAT_W = 4;
  localparam int EXT_W  = DATA_W - 2;

  localparam int B_DTR  = 0;
  localparam int B_RTS  = 1;
  localparam int B_LRI  = 2;
  localparam int B_IEN  = 3;
  localparam int B_LOOP = 4;

  typedef struct packed {
    logic [MSEL_W-1:0] msel;
    logic              ir_pls;
    logic              tx_dfr;
    logic              dma_en;
  } ext_cfg_t;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic cts;
    logic dsr;
  } mstat_t;
endpackage

// File: rtl/mcr_store.sv
module mcr_store
  import mcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              alias_we_i,
  input  logic              alias_loop_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              lri_o,
  output logic              ien_o,
  output logic              loop_o,
  output ext_cfg_t          ext_o
);
  logic     dtr_q, rts_q, lri_q, ien_q, loop_q;
  ext_cfg_t ext_q;

  logic wr_leg, wr_ext;
  assign wr_leg = wr_en_i && !ext_mode_i;
  assign wr_ext = wr_en_i && ext_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtr_q  <= 1'b0;
      rts_q  <= 1'b0;
      lri_q  <= 1'b0;
      ien_q  <= 1'b0;
      loop_q <= 1'b0;
      ext_q  <= '0;
    end else begin
      if (wr_en_i) begin
        dtr_q <= wr_data_i[B_DTR];
        rts_q <= wr_data_i[B_RTS];
      end
      if (wr_ext) ext_q <= ext_cfg_t'(wr_data_i[DATA_W-1:2]);
      if (wr_leg) begin
        lri_q <= wr_data_i[B_LRI];
        ien_q <= wr_data_i[B_IEN];
      end
      // alias path wins over a same-cycle register write
      if (alias_we_i)  loop_q <= alias_loop_i;
      else if (wr_leg) loop_q <= wr_data_i[B_LOOP];
    end
  end

  assign dtr_o  = dtr_q;
  assign rts_o  = rts_q;
  assign lri_o  = lri_q;
  assign ien_o  = ien_q;
  assign loop_o = loop_q;
  assign ext_o  = ext_q;

  p_loop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alias_we_i && !wr_leg) |=> $stable(loop_q));
  p_alias_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_we_i |=> (loop_q == $past(alias_loop_i)));
  p_ext_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ext |=> $stable(ext_q));
  p_leg_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_leg |=> $stable({lri_q, ien_q}));
endmodule

// File: rtl/mcr_route.sv
module mcr_route
  import mcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              dtr_i,
  input  logic              rts_i,
  input  logic              lri_i,
  input  logic              ien_i,
  input  logic              loop_i,
  input  ext_cfg_t          ext_i,
  input  logic [STAT_W-1:0] ext_stat_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dtr_no_o,
  output logic              rts_no_o,
  output logic              irq_en_o,
  output logic [STAT_W-1:0] mstat_o,
  output logic              dma_en_o,
  output logic              tx_defer_o,
  output logic              ir_pulse_o,
  output logic [MSEL_W-1:0] mode_sel_o
);
  mstat_t lb_leg, lb_ext;
  logic [STAT_W-1:0] lb_src;

  always_comb begin
    lb_leg = '{dcd: ien_i, ri: lri_i, cts: rts_i, dsr: dtr_i};
    lb_ext = '{dcd: rts_i, ri: dtr_i, cts: rts_i, dsr: dtr_i};
  end
  assign lb_src = ext_mode_i ? lb_ext : lb_leg;

  for (genvar g = 0; g < STAT_W; g++) begin : g_lane
    assign mstat_o[g] = loop_i ? lb_src[g] : ext_stat_i[g];
  end

  assign dtr_no_o = loop_i | ~dtr_i;
  assign rts_no_o = loop_i | ~rts_i;
  assign irq_en_o = ext_mode_i | loop_i | ien_i;

  assign dma_en_o   = ext_mode_i & ext_i.dma_en;
  assign tx_defer_o = ext_mode_i & ext_i.tx_dfr;
  assign ir_pulse_o = ext_mode_i & ext_i.ir_pls;
  assign mode_sel_o = ext_mode_i ? ext_i.msel : '0;

  always_comb begin
    rd_data_o = '0;
    rd_data_o[B_DTR] = dtr_i;
    rd_data_o[B_RTS] = rts_i;
    if (ext_mode_i) rd_data_o[DATA_W-1:2] = ext_i;
    else begin
      rd_data_o[B_LRI]  = lri_i;
      rd_data_o[B_IEN]  = ien_i;
      rd_data_o[B_LOOP] = loop_i;
    end
  end

  p_pins_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> (dtr_no_o && rts_no_o));
  p_ext_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_i && ext_mode_i) |-> (mstat_o[0] == mstat_o[2] && mstat_o[1] == mstat_o[3]));
  p_irq_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_i || ext_mode_i) |-> irq_en_o);
  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> (rd_data_o[DATA_W-1:B_LOOP+1] == '0));
  p_leg_export_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> (!dma_en_o && !tx_defer_o && !ir_pulse_o && mode_sel_o == '0));
endmodule

// File: rtl/mcr_dual_view.sv
module mcr_dual_view
  import mcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_mode_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              alias_we_i,
  input  logic              alias_loop_i,
  input  logic [STAT_W-1:0] ext_stat_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dtr_no_o,
  output logic              rts_no_o,
  output logic              irq_en_o,
  output logic [STAT_W-1:0] mstat_o,
  output logic              loop_o,
  output logic              dma_en_o,
  output logic              tx_defer_o,
  output logic              ir_pulse_o,
  output logic [MSEL_W-1:0] mode_sel_o
);
  logic     dtr, rts, lri, ien, loop;
  ext_cfg_t ext_cfg;

  mcr_store u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_mode_i   (ext_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .alias_we_i   (alias_we_i),
    .alias_loop_i (alias_loop_i),
    .dtr_o        (dtr),
    .rts_o        (rts),
    .lri_o        (lri),
    .ien_o        (ien),
    .loop_o       (loop),
    .ext_o        (ext_cfg)
  );

  mcr_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .dtr_i      (dtr),
    .rts_i      (rts),
    .lri_i      (lri),
    .ien_i      (ien),
    .loop_i     (loop),
    .ext_i      (ext_cfg),
    .ext_stat_i (ext_stat_i),
    .rd_data_o  (rd_data_o),
    .dtr_no_o   (dtr_no_o),
    .rts_no_o   (rts_no_o),
    .irq_en_o   (irq_en_o),
    .mstat_o    (mstat_o),
    .dma_en_o   (dma_en_o),
    .tx_defer_o (tx_defer_o),
    .ir_pulse_o (ir_pulse_o),
    .mode_sel_o (mode_sel_o)
  );

  assign loop_o = loop;

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0 || wr_en_i || alias_we_i || $past(wr_en_i) || $past(alias_we_i)));
endmodule

// File: tb/mcr_dual_view_tb_top.sv
module mcr_dual_view_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0, wr_en = 1'b0, alias_we = 1'b0, alias_d = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] ext_stat = '0;
  logic [7:0] rd_data;
  logic       dtr_no, rts_no, irq_en, loop, dma_en, tx_defer, ir_pulse;
  logic [3:0] mstat;
  logic [2:0] mode_sel;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcr_dual_view dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .alias_we_i(alias_we), .alias_loop_i(alias_d),
    .ext_stat_i(ext_stat), .rd_data_o(rd_data), .dtr_no_o(dtr_no),
    .rts_no_o(rts_no), .irq_en_o(irq_en), .mstat_o(mstat), .loop_o(loop),
    .dma_en_o(dma_en), .tx_defer_o(tx_defer), .ir_pulse_o(ir_pulse),
    .mode_sel_o(mode_sel)
  );

  // {mode, we, wdata[8], alias_we, alias_d, stat_in[4], exp_rd[8], exp_stat[4], exp_pins[4]}
  // exp_pins = {dtr_no, rts_no, irq_en, loop}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0,1'b1,8'h03,1'b0,1'b0,4'b1010,8'h03,4'b1010,4'b0000},
    {1'b0,1'b1,8'hE9,1'b0,1'b0,4'b0101,8'h09,4'b0101,4'b0110},
    {1'b1,1'b1,8'hB6,1'b0,1'b0,4'b0011,8'hB6,4'b0011,4'b1010},
    {1'b0,1'b0,8'h00,1'b0,1'b0,4'b1111,8'h0A,4'b1111,4'b1010},
    {1'b0,1'b1,8'h15,1'b0,1'b0,4'b0000,8'h15,4'b0101,4'b1111},
    {1'b1,1'b0,8'h00,1'b0,1'b0,4'b0000,8'hB5,4'b0101,4'b1111},
    {1'b1,1'b1,8'h02,1'b0,1'b0,4'b0000,8'h02,4'b1010,4'b1111},
    {1'b1,1'b0,8'h00,1'b1,1'b0,4'b1100,8'h02,4'b1100,4'b1010},
    {1'b0,1'b1,8'h10,1'b1,1'b0,4'b0110,8'h00,4'b0110,4'b1100},
    {1'b0,1'b0,8'h00,1'b1,1'b1,4'b0000,8'h10,4'b0000,4'b1111},
    {1'b1,1'b0,8'h00,1'b0,1'b0,4'b1111,8'h00,4'b0000,4'b1111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic we, input logic [7:0] d,
                       input logic awe, input logic ad, input logic [3:0] st);
    @(negedge clk);
    ext_mode = m; wr_en = we; wr_data = d; alias_we = awe; alias_d = ad; ext_stat = st;
    @(negedge clk);
    wr_en = 1'b0; alias_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd", {24'h0, rd_data}, 32'h00);
    chk("R1 pins", {28'h0, dtr_no, rts_no, irq_en, loop}, 32'b1100);
    ext_mode = 1'b1;
    @(negedge clk);
    chk("R1 ext exports", {26'h0, dma_en, tx_defer, ir_pulse, mode_sel}, 32'h0);
    ext_mode = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31], VEC[i][30], VEC[i][29:22], VEC[i][21], VEC[i][20], VEC[i][19:16]);
      chk("R9 rd", {24'h0, rd_data}, {24'h0, VEC[i][15:8]});
      chk("R3/R4/R5 stat", {28'h0, mstat}, {28'h0, VEC[i][7:4]});
      chk("R2/R6/R7 pins", {28'h0, dtr_no, rts_no, irq_en, loop}, {28'h0, VEC[i][3:0]});
    end

    // R10 exports in extended view
    drive(1'b1, 1'b1, 8'hB6, 1'b0, 1'b0, 4'h0);
    chk("R10 ext exports", {26'h0, dma_en, tx_defer, ir_pulse, mode_sel}, {26'h0, 1'b1, 1'b0, 1'b1, 3'b101});
    drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
    chk("R10 legacy zero", {26'h0, dma_en, tx_defer, ir_pulse, mode_sel}, 32'h0);

    // R8 legacy write keeps extended bits across mode changes
    drive(1'b0, 1'b1, 8'h0C, 1'b0, 1'b0, 4'h0);
    drive(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
    chk("R8 ext bits kept", {24'h0, rd_data}, 32'hB4);
    drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
    chk("R8 legacy bits kept", {24'h0, rd_data}, 32'h0C);

    // R1 mid-run asynchronous reset
    drive(1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 4'h0);
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear", {23'h0, loop, rd_data}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ext_mode = 1'b1;
    @(negedge clk);
    chk("R1 ext cleared", {24'h0, rd_data}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule